// File: doc/BRIEF.md
# Erase, Program and Verify Sequencer for a Byte-wide Reprogrammable Memory

This block is a clocked state machine that takes a byte-wide, electrically erasable memory through one full reprogramming run. It drives the memory's chip-enable, output-enable and write-enable strobes, its address and its data bus. It also drives two digital requests: one for the high programming voltage on the output-enable pin, and one for the high voltage on address line 9. External analog switches turn those requests into the real supervoltage.

A run starts with a single chip-erase pulse. A blank check follows, which reads back every location and expects all ones. Each byte is then fetched from a source port and written with one write-enable pulse. Once the supervoltage is removed and a recovery time has passed, every location is read again and compared with a fresh fetch of its source byte. The run ends with `done` high and with `pass` or the first failing address, together with the phase in which the failure was found.

All timing windows are derived from the clock frequency (`CLK_KHZ`) and from microsecond parameters. These are the erase pulse (default 150000 us), the program pulse (default 20 us), the setup and hold window (default 2 us), the recovery wait (default 2 us) and the read strobe (default 100 ns). `ADDR_W` sets the array size; the last address is all ones.

Top module: `prog_seq`

## Requirements
- R1: Out of reset, and in idle, `ce_n`, `oe_n` and `we_n` are 1, both supervoltage requests are 0, `done` and `src_req` are 0, and `phase` is 0.
- R2: On `start`, `ce_n` goes low and both `hv_oe_en` and `hv_a9_en` go high at least SETUP_US before `we_n` falls. `we_n` then stays low for exactly ERASE_US, and both requests stay high for at least SETUP_US after `we_n` rises. `hv_a9_en` is never high without `hv_oe_en`.
- R3: After the supervoltage requests drop, `oe_n` stays high for at least RECOV_US before the next read.
- R4: The blank check reads addresses 0 up to all ones and expects FFh at each. At the first mismatch the run ends with `done`=1, `pass`=0, `fail_addr` set to that address and `phase`=1, and no program pulse is issued.
- R5: Programming visits the addresses in ascending order up to all ones. Each byte is fetched through `src_req`/`src_addr`, and a byte is taken when `src_valid` is 1. Each byte gets exactly one `we_n` pulse of PROG_US, with `hv_oe_en`=1 and `hv_a9_en`=0. Address and data are held stable for at least SETUP_US before and after the pulse, while `ce_n` is low.
- R6: `hv_oe_en` stays high without a break from before the first program pulse until after the last one. No program pulse is issued unless an erase pulse came earlier in the same run.
- R7: After programming, each address from 0 up to all ones is read and compared with its re-fetched source byte. At the first mismatch the run ends with `pass`=0, `fail_addr` set to that address and `phase`=3.
- R8: If every compare matches, `done`=1 and `pass`=1, and the memory holds the source image. While `done` is 1, all strobes are high and no supervoltage is requested.
- R9: When `abort` is 1 at a clock edge, the outputs after that edge have all strobes at 1, both supervoltage requests at 0 and `done` at 0, and the block stays idle.
- R10: `phase` encodes 0 = erase, 1 = blank check, 2 = program and 3 = verify. It only steps upward through these values during a run, and it holds the phase of the result while `done` is 1.
- R11: Each read drives `ce_n` and `oe_n` low on a stable address for at least READ_NS (at least one cycle) before the data is sampled, and `mem_wdata_oe` is never 1 while `oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run from idle or from done |
| abort | input | 1 | Returns to idle with all strobes released |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Byte to program |
| mem_wdata_oe | output | 1 | Drive enable for the memory data bus |
| mem_rdata | input | DATA_W | Byte read from the memory |
| ce_n | output | 1 | Chip-enable strobe, active low |
| oe_n | output | 1 | Output-enable strobe (logic level), active low |
| we_n | output | 1 | Write-enable strobe, active low |
| hv_oe_en | output | 1 | Request for supervoltage on the output-enable pin |
| hv_a9_en | output | 1 | Request for supervoltage on address line 9 |
| src_req | output | 1 | Source byte request |
| src_addr | output | ADDR_W | Address of the requested source byte |
| src_valid | input | 1 | Source byte response valid |
| src_data | input | DATA_W | Source byte |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without mismatch |
| fail_addr | output | ADDR_W | First mismatching address |
| phase | output | 2 | Current or final phase code |

## Verification
A wrong state in this sequencer shows up at the strobes within one cycle. A stray `we_n` edge or a supervoltage request at the wrong time appears the moment the state is entered. A wrong timer limit shows up as a pulse, setup, hold or recovery window of the wrong length, which is measured on the first pulse of the run. A faulty address stepper shows up either as a program pulse whose address or data differs from the scoreboard's next item, or as a hole in the set of addresses seen during the read phases. A broken compare path shows up only at the end of a run, as a wrong `pass`, `fail_addr` or `phase`. Injected memory faults (a byte that is not blank, and a cell stuck at 0) make sure both compare paths are exercised.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

   typedef enum logic [1:0] {
      PH_ERASE  = 2'd0,
      PH_BLANK  = 2'd1,
      PH_PROG   = 2'd2,
      PH_VERIFY = 2'd3
   } phase_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_E_SET,
      S_E_PULSE,
      S_E_HOLD,
      S_E_REC,
      S_B_READ,
      S_P_VSET,
      S_P_FETCH,
      S_P_SET,
      S_P_PULSE,
      S_P_HOLD,
      S_P_REC,
      S_V_FETCH,
      S_V_READ,
      S_DONE
   } state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/prog_seq_timer.sv
module prog_seq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (cnt != '1)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/prog_seq_addr.sv
module prog_seq_addr #(
   parameter int AW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [AW-1:0] addr,
   output logic          last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr <= '0;
      else if (clr)   addr <= '0;
      else if (inc)   addr <= addr + 1'b1;
   end

   assign last = &addr;
endmodule

// File: rtl/prog_seq.sv
module prog_seq
   import prog_seq_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int CLK_KHZ  = 125000,
   parameter int ERASE_US = 150000,
   parameter int PROG_US  = 20,
   parameter int SETUP_US = 2,
   parameter int RECOV_US = 2,
   parameter int READ_NS  = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wdata_oe,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              ce_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              hv_oe_en,
   output logic              hv_a9_en,
   output logic              src_req,
   output logic [ADDR_W-1:0] src_addr,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              done,
   output logic              pass,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [1:0]        phase
);
   localparam int CYC_US    = CLK_KHZ / 1000;
   localparam int ERASE_CYC = ERASE_US * CYC_US;
   localparam int PROG_CYC  = PROG_US * CYC_US;
   localparam int SETUP_CYC = SETUP_US * CYC_US;
   localparam int RECOV_CYC = RECOV_US * CYC_US;
   localparam int READ_CYC  = max2(1, (READ_NS * CLK_KHZ + 999999) / 1000000);
   localparam int MAX_CYC   = max2(max2(ERASE_CYC, PROG_CYC),
                                   max2(max2(SETUP_CYC, RECOV_CYC), READ_CYC));
   localparam int TW        = $clog2(MAX_CYC + 1);

   localparam logic [TW-1:0] T_ERASE = TW'(ERASE_CYC - 1);
   localparam logic [TW-1:0] T_PROG  = TW'(PROG_CYC - 1);
   localparam logic [TW-1:0] T_SET   = TW'(SETUP_CYC - 1);
   localparam logic [TW-1:0] T_REC   = TW'(RECOV_CYC - 1);
   localparam logic [TW-1:0] T_READ  = TW'(READ_CYC - 1);
   localparam logic [DATA_W-1:0] BLANK = '1;

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 4 || ADDR_W > 19) begin : g_bad_aw
         $error("prog_seq: ADDR_W must lie in 4..19");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("prog_seq: DATA_W must be positive");
      end
      if (CLK_KHZ < 1000 || (CLK_KHZ % 1000) != 0) begin : g_bad_clk
         $error("prog_seq: CLK_KHZ must be a whole number of MHz");
      end
      if (ERASE_US < 1 || PROG_US < 1 || SETUP_US < 1 || RECOV_US < 1) begin : g_bad_us
         $error("prog_seq: every timing window must be at least 1 us");
      end
   endgenerate

   state_e              st_q, st_d;
   phase_e              ph_q, ph_d;
   logic                pass_q, pass_d;
   logic [ADDR_W-1:0]   fa_q, fa_d;
   logic [DATA_W-1:0]   data_q;
   logic                data_ld;
   logic                a_clr, a_inc, a_last;
   logic [ADDR_W-1:0]   addr;
   logic [TW-1:0]       tcnt;
   logic                t_clr;

   prog_seq_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(t_clr), .cnt(tcnt)
   );

   prog_seq_addr #(.AW(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc),
      .addr(addr), .last(a_last)
   );

   always_comb begin
      st_d    = st_q;
      ph_d    = ph_q;
      pass_d  = pass_q;
      fa_d    = fa_q;
      a_clr   = 1'b0;
      a_inc   = 1'b0;
      data_ld = 1'b0;
      unique case (st_q)
         S_IDLE, S_DONE: if (start) begin
            st_d = S_E_SET; ph_d = PH_ERASE; pass_d = 1'b0; fa_d = '0; a_clr = 1'b1;
         end
         S_E_SET:   if (tcnt == T_SET)   st_d = S_E_PULSE;
         S_E_PULSE: if (tcnt == T_ERASE) st_d = S_E_HOLD;
         S_E_HOLD:  if (tcnt == T_SET)   st_d = S_E_REC;
         S_E_REC:   if (tcnt == T_REC) begin
            st_d = S_B_READ; ph_d = PH_BLANK; a_clr = 1'b1;
         end
         S_B_READ: if (tcnt == T_READ) begin
            if (mem_rdata != BLANK) begin
               st_d = S_DONE; fa_d = addr;
            end else if (a_last) begin
               st_d = S_P_VSET; ph_d = PH_PROG; a_clr = 1'b1;
            end else begin
               a_inc = 1'b1;
            end
         end
         S_P_VSET:  if (tcnt == T_SET) st_d = S_P_FETCH;
         S_P_FETCH: if (src_valid) begin
            st_d = S_P_SET; data_ld = 1'b1;
         end
         S_P_SET:   if (tcnt == T_SET)  st_d = S_P_PULSE;
         S_P_PULSE: if (tcnt == T_PROG) st_d = S_P_HOLD;
         S_P_HOLD:  if (tcnt == T_SET) begin
            if (a_last) st_d = S_P_REC;
            else begin
               st_d = S_P_FETCH; a_inc = 1'b1;
            end
         end
         S_P_REC: if (tcnt == T_REC) begin
            st_d = S_V_FETCH; ph_d = PH_VERIFY; a_clr = 1'b1;
         end
         S_V_FETCH: if (src_valid) begin
            st_d = S_V_READ; data_ld = 1'b1;
         end
         S_V_READ: if (tcnt == T_READ) begin
            if (mem_rdata != data_q) begin
               st_d = S_DONE; fa_d = addr;
            end else if (a_last) begin
               st_d = S_DONE; pass_d = 1'b1;
            end else begin
               st_d = S_V_FETCH; a_inc = 1'b1;
            end
         end
         default: st_d = S_IDLE;
      endcase
      if (abort) begin
         st_d = S_IDLE; ph_d = PH_ERASE; pass_d = 1'b0; fa_d = '0;
         a_inc = 1'b0; data_ld = 1'b0;
      end
   end

   assign t_clr = (st_d != st_q) || a_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         ph_q   <= PH_ERASE;
         pass_q <= 1'b0;
         fa_q   <= '0;
         data_q <= '0;
      end else begin
         st_q   <= st_d;
         ph_q   <= ph_d;
         pass_q <= pass_d;
         fa_q   <= fa_d;
         if (data_ld) data_q <= src_data;
      end
   end

   // strobes and requests decoded from the registered state only
   assign ce_n         = (st_q == S_IDLE) || (st_q == S_DONE);
   assign oe_n         = !((st_q == S_B_READ) || (st_q == S_V_READ));
   assign we_n         = !((st_q == S_E_PULSE) || (st_q == S_P_PULSE));
   assign hv_a9_en     = (st_q == S_E_SET) || (st_q == S_E_PULSE) || (st_q == S_E_HOLD);
   assign hv_oe_en     = hv_a9_en || (st_q == S_P_VSET) || (st_q == S_P_FETCH) ||
                         (st_q == S_P_SET) || (st_q == S_P_PULSE) || (st_q == S_P_HOLD);
   assign mem_wdata_oe = (st_q == S_P_SET) || (st_q == S_P_PULSE) || (st_q == S_P_HOLD);
   assign src_req      = (st_q == S_P_FETCH) || (st_q == S_V_FETCH);
   assign mem_addr     = addr;
   assign src_addr     = addr;
   assign mem_wdata    = data_q;
   assign done         = (st_q == S_DONE);
   assign pass         = pass_q;
   assign fail_addr    = fa_q;
   assign phase        = ph_q;

endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int ERASE_CYC = 1,
   parameter int PROG_CYC  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_wdata_oe,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              hv_oe_en,
   input logic              hv_a9_en,
   input logic              done
);
   logic [31:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     low_cnt <= '0;
      else if (!we_n) low_cnt <= low_cnt + 1'b1;
      else            low_cnt <= '0;
   end

   assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (we_n && ce_n && oe_n && !hv_oe_en && !hv_a9_en && !done));

   assert_erase_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(we_n) && hv_a9_en) |-> (low_cnt == 32'(ERASE_CYC)));

   assert_prog_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(we_n) && hv_oe_en && !hv_a9_en) |-> (low_cnt == 32'(PROG_CYC)));

   assert_a9_needs_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hv_a9_en |-> hv_oe_en);

   assert_pulse_under_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n);

   assert_hv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(we_n) && !$past(abort)) |-> hv_oe_en);

   assert_pulse_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> ($stable(mem_addr) && $stable(mem_wdata) && $past(hv_oe_en)));

   assert_no_contention_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wdata_oe |-> oe_n);

   assert_read_no_hv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !hv_oe_en);

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (we_n && ce_n && oe_n && !hv_oe_en));

endmodule

bind prog_seq prog_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .abort(abort), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_wdata_oe(mem_wdata_oe), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
   .hv_oe_en(hv_oe_en), .hv_a9_en(hv_a9_en), .done(done)
);

// File: tb/prog_seq_tb.sv
module prog_seq_tb;
   localparam int AW  = 4;
   localparam int N   = 16;
   localparam int SET = 2;
   localparam int ERA = 120;
   localparam int PRG = 20;
   localparam int REC = 3;
   localparam int RD  = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, start, abort;
   logic [AW-1:0] mem_addr, src_addr, fail_addr;
   logic [7:0]    mem_wdata, mem_rdata, src_data;
   logic          mem_wdata_oe, ce_n, oe_n, we_n, hv_oe_en, hv_a9_en;
   logic          src_req, src_valid, done, pass;
   logic [1:0]    phase;

   logic [7:0] mem [N];
   logic [7:0] src_mem [N];
   logic blank_fault = 1'b0, stuck_fault = 1'b0, abort_win = 1'b0;

   int n_chk = 0, n_fail = 0;

   typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } item_t;
   item_t exp_q[$];

   prog_seq #(.ADDR_W(AW), .DATA_W(8), .CLK_KHZ(1000), .ERASE_US(ERA), .PROG_US(PRG),
              .SETUP_US(SET), .RECOV_US(REC), .READ_NS(2000)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
      .mem_rdata(mem_rdata), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .hv_oe_en(hv_oe_en), .hv_a9_en(hv_a9_en), .src_req(src_req), .src_addr(src_addr),
      .src_valid(src_valid), .src_data(src_data), .done(done), .pass(pass),
      .fail_addr(fail_addr), .phase(phase)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model: combinational read, with an optional non-blank byte at address 5
   assign mem_rdata = (!ce_n && !oe_n) ?
                      (mem[mem_addr] ^ ((blank_fault && mem_addr == 4'd5) ? 8'h10 : 8'h00)) : 8'h00;

   // source port: one-cycle response
   initial src_valid = 1'b0;
   always @(posedge clk) begin
      src_valid <= src_req && !src_valid;
      src_data  <= src_mem[src_addr];
   end

   // monitor / scoreboard
   int n_erase = 0, n_prog = 0;
   bit erased = 0, ph_bad = 0;
   logic [N-1:0] blank_mask = '0, ver_mask = '0;
   logic prev_we = 1'b1, prev_hv = 1'b0;
   logic [AW-1:0] prev_addr = '0, rd_addr = '0;
   logic [7:0] prev_data = '0;
   logic [1:0] prev_ph = '0;
   int low_cnt = 0, hv_cnt = 0, addr_cnt = 0, data_cnt = 0;
   int hold_cnt = 0, rec_cnt = 0, rd_cnt = 0;
   bit hold_arm = 0, rec_arm = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_we && !we_n) begin
            low_cnt = 1;
            if (!abort_win)
               chk(hv_cnt >= SET, hv_a9_en ? "R2" : "R5", "supervoltage setup", hv_cnt, SET);
            if (hv_a9_en) begin
               n_erase++;
               erased = 1;
               for (int i = 0; i < N; i++) mem[i] = 8'hFF;
            end else begin
               item_t it;
               n_prog++;
               chk(erased, "R6", "program pulse preceded by erase", int'(erased), 1);
               chk(addr_cnt >= SET, "R5", "address setup", addr_cnt, SET);
               chk(data_cnt >= SET, "R5", "data setup", data_cnt, SET);
               chk(!ce_n, "R5", "chip enable during pulse", int'(ce_n), 0);
               if (exp_q.size() == 0) chk(0, "R5", "unexpected program pulse", int'(mem_addr), 0);
               else begin
                  it = exp_q.pop_front();
                  chk(it.a == mem_addr && it.d == mem_wdata, "R5", "program address/data",
                      int'({mem_addr, mem_wdata}), int'({it.a, it.d}));
               end
               mem[mem_addr] = mem[mem_addr] & mem_wdata &
                               ((stuck_fault && mem_addr == 4'd9) ? 8'hFE : 8'hFF);
            end
         end else if (!we_n) begin
            low_cnt++;
         end

         if (!prev_we && we_n && !abort_win) begin
            chk(low_cnt == (hv_a9_en ? ERA : PRG), hv_a9_en ? "R2" : "R5", "pulse width",
                low_cnt, hv_a9_en ? ERA : PRG);
            hold_arm = 1; hold_cnt = 1;
         end else if (hold_arm) begin
            if (mem_addr != prev_addr || !hv_oe_en) begin
               chk(hold_cnt >= SET, "R5", "address/supervoltage hold", hold_cnt, SET);
               hold_arm = 0;
            end else hold_cnt++;
         end

         if (prev_hv && !hv_oe_en && phase == 2'd2 && !abort_win)
            chk(n_prog == N, "R6", "supervoltage held through all bytes", n_prog, N);

         if (prev_hv && !hv_oe_en) begin
            rec_arm = 1; rec_cnt = 1;
         end else if (rec_arm) begin
            if (!oe_n) begin
               chk(rec_cnt >= REC, "R3", "recovery before read", rec_cnt, REC);
               rec_arm = 0;
            end else rec_cnt++;
         end

         if (!oe_n) begin
            chk(!mem_wdata_oe, "R11", "data bus driven during read", int'(mem_wdata_oe), 0);
            if (phase == 2'd1) blank_mask[mem_addr] = 1'b1;
            if (phase == 2'd3) ver_mask[mem_addr] = 1'b1;
            if (rd_cnt > 0 && mem_addr != rd_addr) begin
               chk(rd_cnt >= RD, "R11", "read strobe length", rd_cnt, RD);
               rd_cnt = 1;
            end else rd_cnt++;
            rd_addr = mem_addr;
         end else if (rd_cnt > 0) begin
            chk(rd_cnt >= RD, "R11", "read strobe length", rd_cnt, RD);
            rd_cnt = 0;
         end

         if (phase != prev_ph && phase != 2'd0 && phase != prev_ph + 2'd1) ph_bad = 1;

         hv_cnt   = hv_oe_en ? hv_cnt + 1 : 0;
         addr_cnt = (mem_addr != prev_addr) ? 1 : addr_cnt + 1;
         data_cnt = (mem_wdata != prev_data) ? 1 : data_cnt + 1;
      end
      prev_we   = we_n;
      prev_hv   = hv_oe_en;
      prev_addr = mem_addr;
      prev_data = mem_wdata;
      prev_ph   = phase;
   end

   // driver: pushes the expected program items, then launches a run
   task automatic run(input bit push);
      @(posedge clk); #2;
      exp_q.delete();
      n_erase = 0; n_prog = 0; erased = 0; ph_bad = 0;
      blank_mask = '0; ver_mask = '0;
      if (push) for (int i = 0; i < N; i++) exp_q.push_back({AW'(i), src_mem[i]});
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (done) break;
      end
      #1;
      chk(done, "R8", "run completed", int'(done), 1);
   endtask

   task automatic check_image(input string req);
      int bad = 0;
      for (int i = 0; i < N; i++) if (mem[i] != src_mem[i]) bad++;
      chk(bad == 0, req, "memory holds source image", bad, 0);
   endtask

   task automatic finish_bench();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "WDOG", "watchdog expired", 0, 1);
      finish_bench();
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; abort = 1'b0;
      for (int i = 0; i < N; i++) begin
         mem[i]     = 8'(i);
         src_mem[i] = 8'hA5 ^ 8'(i * 37);
      end
      src_mem[9] = 8'h3B;
      repeat (3) @(negedge clk);
      #1;
      chk(ce_n && oe_n && we_n, "R1", "strobes idle in reset", int'({ce_n, oe_n, we_n}), 7);
      chk(!hv_oe_en && !hv_a9_en, "R1", "no supervoltage in reset", int'({hv_oe_en, hv_a9_en}), 0);
      chk(!done && !src_req && phase == 2'd0, "R1", "done/req/phase in reset",
          int'({done, src_req, phase}), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(ce_n && we_n && !hv_oe_en, "R1", "idle after reset", int'({ce_n, we_n, hv_oe_en}), 6);

      // run 1: good memory, full pass
      run(1'b1);
      chk(pass, "R8", "pass flag", int'(pass), 1);
      chk(phase == 2'd3, "R10", "final phase verify", int'(phase), 3);
      chk(!ph_bad, "R10", "phase steps upward", int'(ph_bad), 0);
      chk(n_erase == 1, "R2", "one erase pulse", n_erase, 1);
      chk(n_prog == N, "R5", "one pulse per byte", n_prog, N);
      chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
      chk(blank_mask == '1, "R4", "blank check covered all addresses", int'(blank_mask), 16'hFFFF);
      chk(ver_mask == '1, "R7", "verify covered all addresses", int'(ver_mask), 16'hFFFF);
      check_image("R8");

      // run 2: byte 5 not blank after erase
      blank_fault = 1'b1;
      run(1'b0);
      chk(!pass && fail_addr == 4'd5, "R4", "blank check fail address",
          int'({pass, fail_addr}), 5);
      chk(phase == 2'd1, "R10", "fail phase blank", int'(phase), 1);
      chk(n_prog == 0, "R4", "no program after blank fail", n_prog, 0);
      blank_fault = 1'b0;

      // run 3: cell stuck at 0 in byte 9
      stuck_fault = 1'b1;
      run(1'b1);
      chk(!pass && fail_addr == 4'd9, "R7", "verify fail address", int'({pass, fail_addr}), 9);
      chk(phase == 2'd3, "R10", "fail phase verify", int'(phase), 3);
      chk(exp_q.size() == 0, "R5", "all bytes programmed before verify", exp_q.size(), 0);
      stuck_fault = 1'b0;

      // abort during the erase pulse
      abort_win = 1'b1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int k = 0; k < 500; k++) begin
         if (!we_n) break;
         @(negedge clk);
      end
      abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      #1;
      chk(we_n && ce_n && oe_n, "R9", "strobes released after abort", int'({we_n, ce_n, oe_n}), 7);
      chk(!hv_oe_en && !hv_a9_en && !done, "R9", "supervoltage dropped after abort",
          int'({hv_oe_en, hv_a9_en, done}), 0);
      repeat (10) @(negedge clk);
      #1;
      chk(we_n && ce_n && !src_req, "R9", "stays idle after abort", int'({we_n, ce_n, src_req}), 6);
      abort_win = 1'b0;

      // run 4: new image, recovers after abort
      for (int i = 0; i < N; i++) src_mem[i] = 8'h3C + 8'(i * 11);
      run(1'b1);
      chk(pass && phase == 2'd3, "R8", "second image passes", int'({pass, phase}), 7);
      check_image("R8");
      chk(!ph_bad, "R10", "phase steps upward", int'(ph_bad), 0);

      finish_bench();
   end
endmodule